// File: doc/BRIEF.md
# Bus-Hold DMA Transfer Controller

This block moves a run of bytes between one I/O port and memory with no processor involvement. While it is idle it acts as an ordinary slave peripheral: the processor programs a start address, a byte count and a control byte through a small register port. Once enabled, and while the peripheral raises its transfer request, the block asks the processor for the shared bus with a hold request. It waits for hold acknowledge, and only then drives the memory address, the data and the read/write strobes itself.

Each byte takes two clocks. In the source phase the byte is read from the source (I/O port or memory) into an internal holding register. In the destination phase it is written out. After each byte the address steps up by one and the count steps down by one. In burst mode the bus is kept until the count runs out. In cycle-steal mode the bus is handed back after every byte and requested again. When the count reaches zero the hold is dropped, a sticky terminal-count flag is set and an optional interrupt is raised. A read of the status register clears both.

Top module: `bhdma_ctrl`

## Requirements
- R1: After reset, hold_req, all strobes, all output enables, dack and tc_irq are 0, and every register reads back as 0.
- R2: A source strobe (io_rd or mem_rd) occurs only in a cycle that follows a cycle with hold_ack high. mem_addr_oe, strobe_oe and mem_data_oe are 0 whenever the block is not driving a byte cycle.
- R3: A byte cycle is one source clock followed by one destination clock. Control bit 1 sets the direction: 0 gives io_rd then mem_wr, and memory receives the byte read from the port; 1 gives mem_rd then io_wr, and the port receives the byte read from memory at that address.
- R4: Each moved byte increments the address register by one, with carry across bytes, and decrements the count register by one. Offsets 0..1 read the address low/high and offsets 2..3 read the count low/high.
- R5: Burst mode (control bit 2 = 0) keeps hold_req high and completes one byte every two clocks until the count is exhausted, raising hold_req once per block.
- R6: Cycle-steal mode (control bit 2 = 1) moves exactly one byte per grant. It then drops hold_req and raises it again only after seeing hold_ack low, so one byte completes every four clocks with one hold_req rise per byte.
- R7: With dreq low, no hold request is raised. A transfer starts or continues only while dreq is high and the count is nonzero.
- R8: When the count reaches zero, hold_req drops, status bit 0 (offset 5) is set and stays set, and control bit 0 (enable) clears. tc_irq follows the status bit when control bit 3 is 1.
- R9: A read of offset 5 clears the terminal-count bit and tc_irq. If the read falls in the same cycle as the final byte, setting wins and the next read returns 1.
- R10: Register writes are ignored while hold_req is high.
- R11: If hold_ack falls during a burst, the byte in flight completes, hold_req stays high, no new byte starts, and the block resumes with the next address once hold_ack returns.
- R12: Enabling with a count of zero raises no hold request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 3 | Register offset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, 0 when cfg_rd is low |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Peripheral acknowledge during a byte cycle |
| hold_req | output | 1 | Bus hold request to the processor |
| hold_ack | input | 1 | Bus hold acknowledge from the processor |
| mem_addr | output | 16 | Memory address |
| mem_addr_oe | output | 1 | Enable for mem_addr |
| mem_rdata | input | 8 | Memory read data |
| mem_wdata | output | 8 | Memory write data |
| mem_data_oe | output | 1 | Enable for mem_wdata |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rdata | input | 8 | Data from the I/O port |
| io_wdata | output | 8 | Data to the I/O port |
| io_rd | output | 1 | I/O port read strobe |
| io_wr | output | 1 | I/O port write strobe |
| strobe_oe | output | 1 | Enable for the four strobes |
| tc_irq | output | 1 | Terminal-count interrupt |

## Verification
Two functions can fall in one clock: the final byte setting the terminal-count flag, and a status read clearing it. The bench holds a status read asserted every cycle across a whole burst. This forces one read to land on the very edge where the last byte completes. The result is correct only if exactly one of those reads returns the flag set and tc_irq is low once reading has stopped. A status read that wiped the flag in the collision cycle would show zero hits.

// File: rtl/bhdma_pkg.sv
package bhdma_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SRC  = 2'd2,
        ST_DST  = 2'd3
    } seq_state_t;

    typedef enum logic {
        DIR_IO2MEM = 1'b0,
        DIR_MEM2IO = 1'b1
    } xfer_dir_t;

    typedef enum logic {
        MODE_BURST = 1'b0,
        MODE_STEAL = 1'b1
    } xfer_mode_t;

    // Control byte, bit 3 down to bit 0
    typedef struct packed {
        logic       irq_en;
        xfer_mode_t mode;
        xfer_dir_t  dir;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic io_rd;
        logic io_wr;
        logic mem_rd;
        logic mem_wr;
    } strobes_t;

    // Which strobe a given phase raises for a given direction
    function automatic strobes_t phase_strobes(seq_state_t st, xfer_dir_t d);
        strobes_t s;
        s = '0;
        if (st == ST_SRC) begin
            if (d == DIR_IO2MEM) s.io_rd  = 1'b1;
            else                 s.mem_rd = 1'b1;
        end else if (st == ST_DST) begin
            if (d == DIR_IO2MEM) s.mem_wr = 1'b1;
            else                 s.io_wr  = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/bhdma_regs.sv
module bhdma_regs
    import bhdma_pkg::*;
#(
    parameter int unsigned AW  = 16,
    parameter int unsigned CW  = 16,
    parameter int unsigned RAW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RAW-1:0]    cfg_addr,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [BYTE_W-1:0] cfg_rdata,
    input  logic              busy,
    input  logic              byte_done,
    output logic [AW-1:0]     cur_addr,
    output ctrl_t             ctrl,
    output logic              cnt_zero,
    output logic              cnt_last,
    output logic              tc_irq
);
    localparam int unsigned ABYTES   = AW / BYTE_W;
    localparam int unsigned CBYTES   = CW / BYTE_W;
    localparam int unsigned OFF_CNT  = ABYTES;
    localparam int unsigned OFF_CTRL = ABYTES + CBYTES;
    localparam int unsigned OFF_STAT = OFF_CTRL + 1;

    logic [AW-1:0] addr_q, addr_d;
    logic [CW-1:0] cnt_q, cnt_d;
    ctrl_t         ctrl_q, ctrl_d;
    logic          tc_q;
    logic          wr_ok;
    logic          tc_set, tc_clr;

    assign wr_ok    = cfg_wr && !busy;
    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CW'(1));
    assign tc_set   = byte_done && cnt_last;
    assign tc_clr   = cfg_rd && (cfg_addr == RAW'(OFF_STAT));

    always_comb begin
        addr_d = addr_q;
        cnt_d  = cnt_q;
        ctrl_d = ctrl_q;
        if (byte_done) begin
            addr_d = addr_q + AW'(1);
            cnt_d  = cnt_q - CW'(1);
        end
        if (tc_set) ctrl_d.enable = 1'b0;
        if (wr_ok) begin
            for (int b = 0; b < int'(ABYTES); b++) begin
                if (cfg_addr == RAW'(b)) addr_d[b*BYTE_W +: BYTE_W] = cfg_wdata;
            end
            for (int b = 0; b < int'(CBYTES); b++) begin
                if (cfg_addr == RAW'(OFF_CNT + b)) cnt_d[b*BYTE_W +: BYTE_W] = cfg_wdata;
            end
            if (cfg_addr == RAW'(OFF_CTRL)) ctrl_d = ctrl_t'(cfg_wdata[3:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
            tc_q   <= 1'b0;
        end else begin
            addr_q <= addr_d;
            cnt_q  <= cnt_d;
            ctrl_q <= ctrl_d;
            if (tc_set)      tc_q <= 1'b1;
            else if (tc_clr) tc_q <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_rd) begin
            for (int b = 0; b < int'(ABYTES); b++) begin
                if (cfg_addr == RAW'(b)) cfg_rdata = addr_q[b*BYTE_W +: BYTE_W];
            end
            for (int b = 0; b < int'(CBYTES); b++) begin
                if (cfg_addr == RAW'(OFF_CNT + b)) cfg_rdata = cnt_q[b*BYTE_W +: BYTE_W];
            end
            if (cfg_addr == RAW'(OFF_CTRL)) cfg_rdata = {4'b0, ctrl_q};
            if (cfg_addr == RAW'(OFF_STAT)) cfg_rdata = {6'b0, busy, tc_q};
        end
    end

    assign cur_addr = addr_q;
    assign ctrl     = ctrl_q;
    assign tc_irq   = tc_q && ctrl_q.irq_en;

    // R4: one step of address and count per moved byte
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> (addr_q == $past(addr_q) + AW'(1)) && (cnt_q == $past(cnt_q) - CW'(1)));

    // R9: the final byte sets the flag even against a clearing read
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        tc_set |=> tc_q);

    // R10: configuration is frozen while the bus is held
    a_r10_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_wr) |=> (ctrl_q.dir == $past(ctrl_q.dir)) && (ctrl_q.mode == $past(ctrl_q.mode)));

endmodule

// File: rtl/bhdma_seq.sv
module bhdma_seq
    import bhdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic              cnt_zero,
    input  logic              cnt_last,
    input  logic              dreq,
    input  logic              hold_ack,
    input  logic [BYTE_W-1:0] io_rdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              hold_req,
    output logic              owned,
    output logic              drive_data,
    output logic              byte_done,
    output strobes_t          strb,
    output logic [BYTE_W-1:0] hold_byte
);
    seq_state_t state, state_d;
    logic       can_start;

    assign can_start = ctrl.enable && !cnt_zero && dreq;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (can_start && !hold_ack) state_d = ST_REQ;
            ST_REQ:  if (hold_ack)               state_d = ST_SRC;
            ST_SRC:                              state_d = ST_DST;
            ST_DST: begin
                if (cnt_last || ctrl.mode == MODE_STEAL || !dreq) state_d = ST_IDLE;
                else if (hold_ack)                                 state_d = ST_SRC;
                else                                               state_d = ST_REQ;
            end
            default:                             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hold_byte <= '0;
        end else begin
            state <= state_d;
            if (state == ST_SRC)
                hold_byte <= (ctrl.dir == DIR_MEM2IO) ? mem_rdata : io_rdata;
        end
    end

    assign hold_req   = (state != ST_IDLE);
    assign owned      = (state == ST_SRC) || (state == ST_DST);
    assign byte_done  = (state == ST_DST);
    assign drive_data = (state == ST_DST) && (ctrl.dir == DIR_IO2MEM);
    assign strb       = phase_strobes(state, ctrl.dir);

    // R2: a byte cycle starts only after a grant was seen
    a_r2_src_needs_ack: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SRC) |-> $past(hold_ack));

    // R3: source phase is always followed by destination phase
    a_r3_src_then_dst: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SRC) |=> (state == ST_DST));

    // R6: cycle-steal gives the bus back after each byte
    a_r6_steal_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DST && ctrl.mode == MODE_STEAL) |=> !hold_req);

    // R11: grant lost mid-burst keeps the request up and waits
    a_r11_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DST && ctrl.mode == MODE_BURST && !cnt_last && dreq && !hold_ack)
        |=> (hold_req && !owned));

    // R12: nothing to move, nothing requested
    a_r12_no_empty_req: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && cnt_zero) |=> !hold_req);

endmodule

// File: rtl/bhdma_ctrl.sv
module bhdma_ctrl
    import bhdma_pkg::*;
#(
    parameter int unsigned AW  = 16,
    parameter int unsigned CW  = 16,
    parameter int unsigned RAW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RAW-1:0]    cfg_addr,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              dreq,
    output logic              dack,
    output logic              hold_req,
    input  logic              hold_ack,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_addr_oe,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        mem_wdata,
    output logic              mem_data_oe,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [7:0]        io_rdata,
    output logic [7:0]        io_wdata,
    output logic              io_rd,
    output logic              io_wr,
    output logic              strobe_oe,
    output logic              tc_irq
);
    ctrl_t             ctrl;
    logic              cnt_zero, cnt_last;
    logic              owned, drive_data, byte_done;
    strobes_t          strb;
    logic [BYTE_W-1:0] hold_byte;

    bhdma_regs #(.AW(AW), .CW(CW), .RAW(RAW)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_addr  (cfg_addr),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (hold_req),
        .byte_done (byte_done),
        .cur_addr  (mem_addr),
        .ctrl      (ctrl),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .tc_irq    (tc_irq)
    );

    bhdma_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .cnt_zero   (cnt_zero),
        .cnt_last   (cnt_last),
        .dreq       (dreq),
        .hold_ack   (hold_ack),
        .io_rdata   (io_rdata),
        .mem_rdata  (mem_rdata),
        .hold_req   (hold_req),
        .owned      (owned),
        .drive_data (drive_data),
        .byte_done  (byte_done),
        .strb       (strb),
        .hold_byte  (hold_byte)
    );

    assign mem_addr_oe = owned;
    assign strobe_oe   = owned;
    assign dack        = owned;
    assign mem_data_oe = drive_data;
    assign mem_wdata   = hold_byte;
    assign io_wdata    = hold_byte;
    assign mem_rd      = strb.mem_rd;
    assign mem_wr      = strb.mem_wr;
    assign io_rd       = strb.io_rd;
    assign io_wr       = strb.io_wr;

    // R2: no bus outputs enabled without an outstanding hold request
    a_r2_oe_needs_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_addr_oe || strobe_oe || mem_data_oe) |-> hold_req);

endmodule

// File: tb/bhdma_ctrl_tb_top.sv
module bhdma_ctrl_tb_top;

    typedef struct {
        bit        to_mem;
        bit [15:0] addr;
        bit [7:0]  data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        dreq = 1'b1;
    logic        dack, hold_req;
    logic        hold_ack = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_addr_oe, mem_data_oe, mem_rd, mem_wr;
    logic [7:0]  mem_rdata, mem_wdata, io_rdata, io_wdata;
    logic        io_rd, io_wr, strobe_oe, tc_irq;

    int checks = 0, fails = 0;
    exp_t sb[$];
    bit   ack_en = 1'b1;
    int   io_seq = 0;
    int   cyc = 0;
    int   dst_count = 0, hold_rises = 0, src_no_ack = 0;
    int   exp_gap = 0, prev_dst = -1;
    logic prev_hold = 1'b0;
    logic [15:0] src_addr = '0;

    always #10 clk = ~clk;

    bhdma_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq), .dack(dack),
        .hold_req(hold_req), .hold_ack(hold_ack), .mem_addr(mem_addr),
        .mem_addr_oe(mem_addr_oe), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_data_oe(mem_data_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rdata(io_rdata), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
        .strobe_oe(strobe_oe), .tc_irq(tc_irq)
    );

    function automatic bit [7:0] io_pat(int s);
        return 8'(s * 7 + 8'h13);
    endfunction
    function automatic bit [7:0] mem_pat(bit [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign mem_rdata = mem_pat(mem_addr);
    assign io_rdata  = io_pat(io_seq);

    // Processor grant model: follows the request one clock later
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (io_rd && !rst) io_seq <= io_seq + 1;
        #2 hold_ack = hold_req && ack_en;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every destination strobe
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_req && !prev_hold) hold_rises++;
            prev_hold = hold_req;
            if ((io_rd || mem_rd) && !hold_ack) src_no_ack++;
            if (mem_rd) src_addr = mem_addr;
            if (mem_wr || io_wr) begin
                exp_t e;
                dst_count++;
                if (exp_gap != 0 && prev_dst >= 0)
                    check(cyc - prev_dst == exp_gap, "R5/R6", "byte spacing", cyc - prev_dst, exp_gap);
                prev_dst = cyc;
                if (sb.size() == 0) begin
                    check(0, "R10", "unexpected byte", int'(mem_addr), 0);
                end else begin
                    e = sb.pop_front();
                    if (mem_wr) begin
                        check(e.to_mem && mem_addr_oe && mem_data_oe && strobe_oe, "R3",
                              "mem write enables", {mem_addr_oe, mem_data_oe}, 3);
                        check(mem_addr == e.addr, "R4", "write address", int'(mem_addr), int'(e.addr));
                        check(mem_wdata == e.data, "R3", "memory data", int'(mem_wdata), int'(e.data));
                    end else begin
                        check(!e.to_mem && !mem_data_oe, "R3", "io write direction", mem_data_oe, 0);
                        check(src_addr == e.addr, "R4", "read address", int'(src_addr), int'(e.addr));
                        check(io_wdata == e.data, "R3", "port data", int'(io_wdata), int'(e.data));
                    end
                end
            end
        end
    end

    task automatic cfg_write(int a, bit [7:0] d);
        @(negedge clk);
        cfg_addr = 3'(a); cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(int a, output bit [7:0] d);
        @(negedge clk);
        cfg_addr = 3'(a); cfg_rd = 1'b1;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    // Driver: programs one transfer and queues the expected bytes
    task automatic setup_xfer(bit [15:0] start, int n, bit dir, bit mode, bit irq_en, bit go);
        bit [7:0] junk;
        cfg_read(5, junk);
        cfg_write(0, start[7:0]);
        cfg_write(1, start[15:8]);
        cfg_write(2, 8'(n));
        cfg_write(3, 8'(n >> 8));
        exp_gap = mode ? 4 : 2;
        prev_dst = -1;
        hold_rises = 0;
        dst_count = 0;
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.to_mem = !dir;
            e.addr   = start + 16'(k);
            e.data   = dir ? mem_pat(start + 16'(k)) : io_pat(io_seq + k);
            sb.push_back(e);
        end
        if (go) cfg_write(4, {4'b0, irq_en, mode, dir, 1'b1});
    endtask

    task automatic wait_idle();
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while ((sb.size() != 0 || hold_req) && k < 4000);
        check(k < 4000, "R8", "transfer finished", sb.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit [7:0] d;
        int hits;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!hold_req && !mem_addr_oe && !strobe_oe && !mem_data_oe && !dack && !tc_irq
              && !io_rd && !io_wr && !mem_rd && !mem_wr, "R1", "outputs idle", hold_req, 0);
        for (int r = 0; r < 6; r++) begin
            cfg_read(r, d);
            check(d == 8'h00, "R1", "register reset", d, 0);
        end

        // R12: enabled with zero count
        cfg_write(4, 8'h01);
        repeat (20) @(negedge clk);
        check(hold_rises == 0 && !hold_req, "R12", "no request on zero count", hold_rises, 0);
        cfg_write(4, 8'h00);

        // R3 R4 R5 R8: burst, port to memory, address carry
        setup_xfer(16'h12FE, 5, 1'b0, 1'b0, 1'b1, 1'b1);
        wait_idle();
        check(hold_rises == 1, "R5", "one hold per burst", hold_rises, 1);
        check(dst_count == 5, "R5", "bytes moved", dst_count, 5);
        cfg_read(0, d); check(d == 8'h03, "R4", "addr low", d, 8'h03);
        cfg_read(1, d); check(d == 8'h13, "R4", "addr high", d, 8'h13);
        cfg_read(2, d); check(d == 8'h00, "R4", "count low", d, 0);
        cfg_read(4, d); check(d[0] == 1'b0, "R8", "enable cleared", d[0], 0);
        check(tc_irq == 1'b1, "R8", "irq raised", tc_irq, 1);
        cfg_read(5, d); check(d[0] == 1'b1, "R8", "tc sticky", d[0], 1);
        @(negedge clk);
        check(tc_irq == 1'b0, "R9", "irq cleared by read", tc_irq, 0);
        cfg_read(5, d); check(d[0] == 1'b0, "R9", "tc cleared by read", d[0], 0);

        // R6: cycle-steal, memory to port
        setup_xfer(16'h0440, 4, 1'b1, 1'b1, 1'b0, 1'b1);
        wait_idle();
        check(hold_rises == 4, "R6", "one hold per byte", hold_rises, 4);
        check(tc_irq == 1'b0, "R8", "irq masked", tc_irq, 0);

        // R7: request line gates the start
        dreq = 1'b0;
        setup_xfer(16'h0200, 3, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        check(hold_rises == 0, "R7", "no hold without dreq", hold_rises, 0);
        dreq = 1'b1;
        wait_idle();
        check(dst_count == 3, "R7", "bytes after dreq", dst_count, 3);

        // R10: write during a transfer is ignored
        setup_xfer(16'h0800, 8, 1'b1, 1'b0, 1'b0, 1'b1);
        while (!hold_req) @(negedge clk);
        cfg_write(2, 8'hFF);
        cfg_write(4, 8'h00);
        wait_idle();
        check(dst_count == 8, "R10", "byte total", dst_count, 8);
        cfg_read(2, d); check(d == 8'h00, "R10", "count after write", d, 0);

        // R11: grant withdrawn mid-burst
        setup_xfer(16'h0A00, 10, 1'b0, 1'b0, 1'b0, 1'b1);
        exp_gap = 0;
        wait (dst_count == 3);
        @(negedge clk);
        ack_en = 1'b0;
        repeat (15) @(negedge clk);
        check(dst_count == 4, "R11", "in-flight byte done only", dst_count, 4);
        check(hold_req == 1'b1, "R11", "hold kept", hold_req, 1);
        check(!mem_addr_oe && !strobe_oe, "R2", "buses released", {mem_addr_oe, strobe_oe}, 0);
        ack_en = 1'b1;
        wait_idle();
        check(dst_count == 10, "R11", "resumed to end", dst_count, 10);
        check(src_no_ack == 0, "R2", "source strobe without grant", src_no_ack, 0);

        // R9: status read held across the final byte
        setup_xfer(16'h0C00, 3, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        cfg_addr = 3'd5; cfg_rd = 1'b1;
        hits = 0;
        for (int k = 0; k < 40; k++) begin
            #1 if (cfg_rdata[0]) hits++;
            @(negedge clk);
        end
        cfg_rd = 1'b0;
        check(sb.size() == 0, "R9", "collision burst done", sb.size(), 0);
        check(hits == 1, "R9", "tc reads seen", hits, 1);
        @(negedge clk);
        check(tc_irq == 1'b0, "R9", "irq after reads", tc_irq, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule